// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves pixel and command words between a system and a display panel over a parallel bus. Each bus cycle is timed in ticks of a divided functional clock. The strobe rises one tick after the cycle begins and falls after a programmed number of ticks. The whole cycle lasts a separately programmed number of ticks. A transfer runs a programmed number of cycles as either writes or reads. A select output marks it as a command phase or a data phase.

Write data enters through a valid/ready push port that takes bytes, halfwords or words. These are packed into bus cycles starting from the least significant byte. Read data leaves through a valid/ready pop port. On the push port, the block holds `wr_ready` low when the byte FIFO lacks room for the offered size, and the source must keep its beat stable until it is accepted. On the pop port, the consumer may hold `rd_ready` low. When the read FIFO cannot take another sample, the engine stops launching read cycles. A DMA request output asks for more write data while a write transfer has room for a word. A done flag reports that every pending write has left the FIFO and reached the bus.

Configuration is sampled on the `start` pulse while the block is idle. A cycle length below three ticks makes the block flush itself instead of running.

Top module: `panel_bus_engine`

## Requirements
- R1: After reset the block is idle. `busy`, `bus_we`, `bus_re`, `dma_req` and `rd_valid` are 0, and `wr_done` is 1.
- R2: One tick lasts `cfg_div_m1`+1 clocks (divider 1 to 8). Each bus cycle lasts `cfg_tw1`+1 ticks. The strobe goes high one tick after the cycle begins and stays high for `cfg_tw0` ticks. The output data is stable while the write strobe is high.
- R3: A transfer runs exactly `cfg_len_m1`+1 bus cycles (an 18-bit field). With no stalls, `busy` stays high for (`cfg_div_m1`+1)·((`cfg_len_m1`+1)·(`cfg_tw1`+1)+1) clocks.
- R4: Bus width is chosen by `cfg_width_m1`: 31 gives 32 bits, 15 gives 16 bits, and any other value gives 8 bits. Write bytes go onto the bus in push order, lowest byte first, and unused upper bus bits are 0.
- R5: Push size code 0 is a byte, 1 is a halfword, and 2 or 3 is a word, each taking its low bytes of `wr_data`. `wr_ready` is 1 exactly when the FIFO has free bytes for the offered size.
- R6: During a write transfer with too few bytes queued for a cycle, no new cycle starts and the strobe stays low until data arrives.
- R7: A read cycle samples `bus_din` one tick after the strobe falls. The sample is masked to the bus width and queued in order on the pop port. With the queue full, no new read cycle starts. `bus_oe` is 0 during reads.
- R8: A `start` while idle with `cfg_tw1` below 2 runs no cycle and flushes both FIFOs. `busy` stays 0 and `wr_done` reads 1 on the next clock.
- R9: `wr_done` is 0 while a write transfer runs or while bytes wait in the write FIFO, and 1 otherwise.
- R10: A `stop` pulse ends any transfer. `busy` is 0 on the next clock.
- R11: `bus_dc` takes `cfg_data_sel` (0 = command, 1 = data) at start and holds it through the transfer.
- R12: `dma_req` is 1 only while a write transfer runs and the write FIFO has at least four free bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer using the cfg_* inputs (idle only) |
| stop | input | 1 | Abort the running transfer |
| cfg_read | input | 1 | 1 = read transfer, 0 = write transfer |
| cfg_data_sel | input | 1 | 0 = command phase, 1 = data phase |
| cfg_div_m1 | input | 3 | Clock divider minus one |
| cfg_tw0 | input | 4 | Strobe-off point in ticks minus one |
| cfg_tw1 | input | 6 | Cycle length in ticks minus one |
| cfg_width_m1 | input | 5 | Bus width in bits minus one |
| cfg_len_m1 | input | 18 | Bus cycle count minus one |
| wr_valid | input | 1 | Push beat offered |
| wr_ready | output | 1 | Push beat accepted this clock if valid |
| wr_data | input | 32 | Push data |
| wr_size | input | 2 | Push size code |
| rd_valid | output | 1 | Read sample available |
| rd_ready | input | 1 | Consumer takes the sample |
| rd_data | output | 32 | Read sample, zero-extended |
| busy | output | 1 | Transfer in progress |
| wr_done | output | 1 | All pending writes completed |
| dma_req | output | 1 | Request for more write data |
| bus_dc | output | 1 | Command/data select on the panel bus |
| bus_oe | output | 1 | Bus data driver enable (writes) |
| bus_we | output | 1 | Write strobe, active high |
| bus_re | output | 1 | Read strobe, active high |
| bus_dout | output | 32 | Bus write data |
| bus_din | input | 32 | Bus read data |

## Verification
The assertions assume a legal configuration. Ticks must satisfy `cfg_tw0` ≥ 1 and `cfg_tw1` ≥ `cfg_tw0`. `start` and `stop` pulse for single clocks. The push beat stays stable until accepted. The bench draws every random trial inside those limits: strobe length 1 to 5, cycle length at least the strobe-off point and at least three ticks, and widths of 8, 16 or 32 bits only. It reaches the short-cycle case only through a directed test. Random timing trials queue all their bytes before `start`, so the cycle count and duration checks see no stalls. Stalls are provoked on purpose in separate directed tests.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  // bytes carried by one push beat
  function automatic logic [2:0] push_bytes(input logic [1:0] code);
    case (code)
      2'd0:    push_bytes = 3'd1;
      2'd1:    push_bytes = 3'd2;
      default: push_bytes = 3'd4;
    endcase
  endfunction

  // bytes carried by one bus cycle
  function automatic logic [2:0] width_bytes(input logic [4:0] w_m1);
    case (w_m1)
      5'd31:   width_bytes = 3'd4;
      5'd15:   width_bytes = 3'd2;
      default: width_bytes = 3'd1;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] lane_mask(input logic [2:0] nb);
    case (nb)
      3'd4:    lane_mask = {BUS_W{1'b1}};
      3'd2:    lane_mask = {{(BUS_W-16){1'b0}}, 16'hFFFF};
      default: lane_mask = {{(BUS_W-8){1'b0}}, 8'hFF};
    endcase
  endfunction
endpackage

// File: rtl/pbe_tick_gen.sv
module pbe_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pbe_wr_fifo.sv
module pbe_wr_fifo import pbe_pkg::*; #(
  parameter int BYTES = 16,
  localparam int PW = $clog2(BYTES),
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  input  logic [1:0]       in_size,
  input  logic             pop,
  input  logic [2:0]       pop_bytes,
  output logic             pop_avail,
  output logic [BUS_W-1:0] pop_data,
  output logic [CW-1:0]    free_bytes
);
  logic [7:0]    mem [BYTES];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic [2:0]    in_nb;
  logic          do_push, do_pop;

  assign in_nb      = push_bytes(in_size);
  assign free_bytes = CW'(BYTES) - count;
  assign in_ready   = free_bytes >= CW'(in_nb);
  assign pop_avail  = count >= CW'(pop_bytes);
  assign do_push    = in_valid && in_ready && !flush;
  assign do_pop     = pop && pop_avail && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + PW'(in_nb);
      if (do_pop)  rp <= rp + PW'(pop_bytes);
      count <= count + (do_push ? CW'(in_nb) : '0) - (do_pop ? CW'(pop_bytes) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      for (int b = 0; b < LANES; b++) begin
        if (b < int'(in_nb)) mem[wp + PW'(b)] <= in_data[8*b +: 8];
      end
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign pop_data[8*g +: 8] = mem[rp + PW'(g)];
    end
  endgenerate
endmodule

// File: rtl/pbe_rd_fifo.sv
module pbe_rd_fifo #(
  parameter int W = 32,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] free
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign free      = CW'(DEPTH) - count;
  assign out_valid = count != '0;
  assign out_data  = mem[rp];
  assign do_push   = push && (count != CW'(DEPTH)) && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end
endmodule

// File: rtl/panel_bus_engine.sv
module panel_bus_engine import pbe_pkg::*; #(
  parameter int WR_BYTES = 16,
  parameter int RD_DEPTH = 4,
  parameter int DIV_W    = 3,
  parameter int TW0_W    = 4,
  parameter int TW1_W    = 6,
  parameter int LEN_W    = 18,
  localparam int PH_W = ((TW1_W > TW0_W) ? TW1_W : TW0_W) + 1,
  localparam int WCW  = $clog2(WR_BYTES + 1),
  localparam int RCW  = $clog2(RD_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_read,
  input  logic             cfg_data_sel,
  input  logic [DIV_W-1:0] cfg_div_m1,
  input  logic [TW0_W-1:0] cfg_tw0,
  input  logic [TW1_W-1:0] cfg_tw1,
  input  logic [4:0]       cfg_width_m1,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [1:0]       wr_size,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [BUS_W-1:0] rd_data,
  output logic             busy,
  output logic             wr_done,
  output logic             dma_req,
  output logic             bus_dc,
  output logic             bus_oe,
  output logic             bus_we,
  output logic             bus_re,
  output logic [BUS_W-1:0] bus_dout,
  input  logic [BUS_W-1:0] bus_din
);
  // transfer state
  logic             run_q, rd_mode_q, dc_q;
  logic [DIV_W-1:0] div_q;
  logic [TW0_W-1:0] tw0_q;
  logic [TW1_W-1:0] tw1_q;
  logic [2:0]       nb_q;
  logic [LEN_W-1:0] rem_q;
  logic [PH_W-1:0]  ph_q;
  logic [BUS_W-1:0] dout_q;

  // control
  logic             tick, short_req, launch, flush;
  logic [PH_W-1:0]  len_end, off_end, samp_a, sample_ph;
  logic             cyc_end, slot, last, sample_now, can_go, try_start, strobe;
  logic             pop_avail;
  logic [BUS_W-1:0] pop_data;
  logic [WCW-1:0]   wr_free;
  logic [RCW-1:0]   rd_free;

  assign short_req = start && !run_q && (cfg_tw1 < TW1_W'(2));
  assign launch    = start && !run_q && !short_req && !stop;
  assign flush     = short_req;

  pbe_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_q),
    .div_m1 (div_q),
    .tick   (tick)
  );

  // phase arithmetic: ph counts ticks since the cycle began (1..len_end)
  assign len_end    = PH_W'(tw1_q) + 1'b1;
  assign off_end    = PH_W'(tw0_q) + 1'b1;
  assign samp_a     = PH_W'(tw0_q) + PH_W'(2);
  assign sample_ph  = (samp_a < len_end) ? samp_a : len_end;
  assign cyc_end    = tick && (ph_q == len_end);
  assign slot       = tick && ((ph_q == '0) || (ph_q == len_end));
  assign last       = rem_q == '0;
  assign sample_now = run_q && tick && rd_mode_q && (ph_q == sample_ph);
  assign can_go     = rd_mode_q ? (rd_free > RCW'(sample_now)) : pop_avail;
  assign try_start  = run_q && !stop && slot && !(cyc_end && last) && can_go;
  assign strobe     = (ph_q >= PH_W'(2)) && (ph_q <= off_end);

  pbe_wr_fifo #(.BYTES(WR_BYTES)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .in_valid   (wr_valid),
    .in_ready   (wr_ready),
    .in_data    (wr_data),
    .in_size    (wr_size),
    .pop        (try_start && !rd_mode_q),
    .pop_bytes  (nb_q),
    .pop_avail  (pop_avail),
    .pop_data   (pop_data),
    .free_bytes (wr_free)
  );

  pbe_rd_fifo #(.W(BUS_W), .DEPTH(RD_DEPTH)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (sample_now),
    .push_data (bus_din & lane_mask(nb_q)),
    .out_valid (rd_valid),
    .out_ready (rd_ready),
    .out_data  (rd_data),
    .free      (rd_free)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      rd_mode_q <= 1'b0;
      dc_q      <= 1'b0;
      div_q     <= '0;
      tw0_q     <= '0;
      tw1_q     <= '0;
      nb_q      <= 3'd1;
      rem_q     <= '0;
      ph_q      <= '0;
      dout_q    <= '0;
    end else if (stop) begin
      run_q <= 1'b0;
      ph_q  <= '0;
    end else if (launch) begin
      run_q     <= 1'b1;
      rd_mode_q <= cfg_read;
      dc_q      <= cfg_data_sel;
      div_q     <= cfg_div_m1;
      tw0_q     <= cfg_tw0;
      tw1_q     <= cfg_tw1;
      nb_q      <= width_bytes(cfg_width_m1);
      rem_q     <= cfg_len_m1;
      ph_q      <= '0;
    end else if (run_q && tick) begin
      if (cyc_end && last) begin
        run_q <= 1'b0;
        ph_q  <= '0;
      end else begin
        if (cyc_end) rem_q <= rem_q - 1'b1;
        if (try_start) begin
          ph_q <= PH_W'(1);
          if (!rd_mode_q) dout_q <= pop_data & lane_mask(nb_q);
        end else if (cyc_end) begin
          ph_q <= '0;
        end else if (ph_q != '0) begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign busy     = run_q;
  assign bus_dc   = dc_q;
  assign bus_oe   = run_q && !rd_mode_q;
  assign bus_we   = run_q && !rd_mode_q && strobe;
  assign bus_re   = run_q && rd_mode_q && strobe;
  assign bus_dout = dout_q;
  assign wr_done  = !(run_q && !rd_mode_q) && (wr_free == WCW'(WR_BYTES));
  assign dma_req  = run_q && !rd_mode_q && (wr_free >= WCW'(4));
endmodule

// File: rtl/pbe_checker.sv
module pbe_checker #(
  parameter int TW1_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [TW1_W-1:0] cfg_tw1,
  input logic             busy,
  input logic             wr_done,
  input logic             dma_req,
  input logic             bus_dc,
  input logic             bus_oe,
  input logic             bus_we,
  input logic             bus_re,
  input logic [31:0]      bus_dout
);
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  a_r4_we_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_oe);

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_we && !bus_re && !bus_oe));

  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we)) |-> $stable(bus_dout));

  a_r10_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy);

  a_r8_short_cycle_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (cfg_tw1 < TW1_W'(2))) |=> (!busy && wr_done));

  a_r11_dc_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(bus_dc));

  a_r12_dma_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dma_req);
endmodule

bind panel_bus_engine pbe_checker #(.TW1_W(TW1_W)) u_pbe_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .stop     (stop),
  .cfg_tw1  (cfg_tw1),
  .busy     (busy),
  .wr_done  (wr_done),
  .dma_req  (dma_req),
  .bus_dc   (bus_dc),
  .bus_oe   (bus_oe),
  .bus_we   (bus_we),
  .bus_re   (bus_re),
  .bus_dout (bus_dout)
);

// File: tb/tb_panel_bus_engine.sv
module tb_panel_bus_engine;
  localparam int CLK_PERIOD = 10;
  localparam int RD_DEPTH   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 0, stop = 0, cfg_read = 0, cfg_data_sel = 0;
  logic [2:0]  cfg_div_m1 = 0;
  logic [3:0]  cfg_tw0 = 1;
  logic [5:0]  cfg_tw1 = 2;
  logic [4:0]  cfg_width_m1 = 7;
  logic [17:0] cfg_len_m1 = 0;
  logic        wr_valid = 0, rd_ready = 0;
  logic [31:0] wr_data = 0, bus_din = 0;
  logic [1:0]  wr_size = 0;
  logic        wr_ready, rd_valid, busy, wr_done, dma_req;
  logic        bus_dc, bus_oe, bus_we, bus_re;
  logic [31:0] rd_data, bus_dout;

  panel_bus_engine #(.RD_DEPTH(RD_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_read(cfg_read), .cfg_data_sel(cfg_data_sel), .cfg_div_m1(cfg_div_m1),
    .cfg_tw0(cfg_tw0), .cfg_tw1(cfg_tw1), .cfg_width_m1(cfg_width_m1),
    .cfg_len_m1(cfg_len_m1), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_size(wr_size), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .busy(busy), .wr_done(wr_done), .dma_req(dma_req),
    .bus_dc(bus_dc), .bus_oe(bus_oe), .bus_we(bus_we), .bus_re(bus_re),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] byte_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    pat = 32'h9E37_79B9 * (k + 1) ^ 32'h5A00_0000;
  endfunction

  function automatic int nb_of(input int wm1);
    nb_of = (wm1 == 31) ? 4 : (wm1 == 15) ? 2 : 1;
  endfunction

  // bus monitor, sampled away from the active edge
  int clk_i = 0, we_n = 0, re_n = 0, rd_n = 0, busy_clks = 0, hi_cnt = 0;
  int rise_t[64];
  int hi_w[64];
  logic [31:0] wcap[64];
  logic        dccap[64];
  logic [31:0] rcap[64];
  logic prev_we = 0, prev_re = 0;

  always @(negedge clk) begin
    clk_i++;
    if (busy) busy_clks++;
    if (bus_we && !prev_we && we_n < 64) begin
      rise_t[we_n] = clk_i; wcap[we_n] = bus_dout; dccap[we_n] = bus_dc; hi_cnt = 0;
    end
    if (bus_we) hi_cnt++;
    if (!bus_we && prev_we && we_n < 64) begin hi_w[we_n] = hi_cnt; we_n++; end
    if (bus_re && !prev_re) begin bus_din <= pat(re_n); re_n++; end
    if (rd_valid && rd_ready && rd_n < 64) begin rcap[rd_n] = rd_data; rd_n++; end
    prev_we = bus_we;
    prev_re = bus_re;
  end

  task automatic clear_mon();
    we_n = 0; re_n = 0; rd_n = 0; busy_clks = 0;
  endtask

  task automatic push(input logic [31:0] d, input int s);
    @(posedge clk); #1;
    wr_valid = 1; wr_data = d; wr_size = 2'(s);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    wr_valid = 0;
    for (int b = 0; b < (1 << s); b++) byte_q.push_back(d[8*b +: 8]);
  endtask

  task automatic go(input bit rd, input bit dc, input int divm1, input int tw0,
                    input int tw1, input int wm1, input int n);
    @(posedge clk); #1;
    cfg_read = rd; cfg_data_sel = dc; cfg_div_m1 = 3'(divm1); cfg_tw0 = 4'(tw0);
    cfg_tw1 = 6'(tw1); cfg_width_m1 = 5'(wm1); cfg_len_m1 = 18'(n - 1);
    start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic check_writes(input int n, input int wm1, input bit dc,
                              input int divm1, input int tw0, input int tw1);
    int nb = nb_of(wm1);
    chk("R3 write cycle count", we_n, n);
    for (int k = 0; k < n && k < we_n; k++) begin
      logic [31:0] w = 0;
      for (int b = 0; b < nb; b++) w[8*b +: 8] = byte_q.pop_front();
      chk("R4 packed bus word", wcap[k], w);
      chk("R11 dc select", dccap[k], dc);
      chk("R2 strobe high clocks", hi_w[k], tw0 * (divm1 + 1));
      if (k > 0) chk("R2 cycle period", rise_t[k] - rise_t[k-1], (tw1 + 1) * (divm1 + 1));
    end
    chk("R9 done after writes", wr_done, 1);
  endtask

  task automatic write_trial(input int divm1, input int tw0, input int tw1,
                             input int wm1, input int n, input bit dc);
    int left = n * nb_of(wm1);
    byte_q.delete();
    while (left > 0) begin
      int s = int'($urandom % 3);
      while ((1 << s) > left) s--;
      push($urandom, s);
      left -= (1 << s);
    end
    clear_mon();
    go(0, dc, divm1, tw0, tw1, wm1, n);
    wait_idle();
    chk("R3 busy duration", busy_clks, (divm1 + 1) * (n * (tw1 + 1) + 1));
    check_writes(n, wm1, dc, divm1, tw0, tw1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2718);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 strobes", {bus_we, bus_re}, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_done", wr_done, 1);

    // directed: 16-bit data phase and 8-bit command phase
    write_trial(0, 1, 2, 15, 4, 1);
    write_trial(3, 2, 5, 7, 5, 0);

    // R5 push acceptance at the FIFO limit
    byte_q.delete();
    for (int i = 0; i < 3; i++) push(pat(i + 20), 2);
    @(negedge clk);
    wr_size = 2'd2;
    #1 chk("R5 ready with room for a word", wr_ready, 1);
    push(pat(30), 2);
    @(negedge clk);
    wr_size = 2'd0;
    #1 chk("R5 not ready when full", wr_ready, 0);
    chk("R9 pending bytes", wr_done, 0);
    clear_mon();
    go(0, 1, 1, 3, 4, 31, 4);
    wait_idle();
    check_writes(4, 31, 1, 1, 3, 4);

    // random timing trials
    for (int t = 0; t < 12; t++) begin
      int divm1 = int'($urandom % 8);
      int tw0 = 1 + int'($urandom % 5);
      int tw1 = tw0 + int'($urandom % 4);
      int sel = int'($urandom % 3);
      int wm1 = (sel == 0) ? 7 : (sel == 1) ? 15 : 31;
      int n;
      if (tw1 < 2) tw1 = 2;
      n = 1 + int'($urandom % (16 / nb_of(wm1)));
      write_trial(divm1, tw0, tw1, wm1, n, bit'($urandom % 2));
    end

    // R6 stall on empty FIFO, R12 request while waiting
    byte_q.delete();
    clear_mon();
    go(0, 1, 0, 1, 2, 15, 2);
    repeat (20) @(negedge clk);
    chk("R6 no strobe while starved", we_n, 0);
    chk("R6 still busy", busy, 1);
    chk("R12 dma request", dma_req, 1);
    chk("R9 not done while writing", wr_done, 0);
    push(32'hBEEF_1234, 2);
    wait_idle();
    check_writes(2, 15, 1, 0, 1, 2);
    chk("R12 no request idle", dma_req, 0);

    // R10 stop
    clear_mon();
    go(0, 0, 2, 1, 3, 7, 6);
    repeat (10) @(negedge clk);
    @(posedge clk); #1 stop = 1;
    @(posedge clk); #1 stop = 0;
    @(negedge clk);
    chk("R10 stopped", busy, 0);

    // R8 short cycle flushes
    byte_q.delete();
    push(32'h0000_AB12, 1);
    push(32'h0000_0033, 0);
    @(negedge clk);
    chk("R9 bytes pending", wr_done, 0);
    clear_mon();
    go(0, 1, 0, 1, 1, 7, 3);
    @(negedge clk);
    chk("R8 no run", busy, 0);
    chk("R8 flushed", wr_done, 1);
    repeat (10) @(negedge clk);
    chk("R8 no strobes", we_n, 0);

    // R7 read with back-pressure, 16-bit
    clear_mon();
    rd_ready = 0;
    go(1, 1, 0, 2, 4, 15, 10);
    repeat (100) @(negedge clk);
    chk("R7 stalls at queue depth", re_n, RD_DEPTH);
    chk("R7 busy while stalled", busy, 1);
    chk("R7 no drive on read", bus_oe, 0);
    @(posedge clk); #1 rd_ready = 1;
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R7 sample count", rd_n, 10);
    for (int k = 0; k < 10 && k < rd_n; k++)
      chk("R7 sample value 16-bit", rcap[k], pat(k) & 32'h0000_FFFF);

    // R7 8-bit read, sample point at cycle end
    clear_mon();
    go(1, 0, 2, 1, 2, 7, 3);
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R7 sample count 8-bit", rd_n, 3);
    for (int k = 0; k < 3 && k < rd_n; k++)
      chk("R7 sample value 8-bit", rcap[k], pat(k) & 32'h0000_00FF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule